// File: doc/BRIEF.md
# Interrupt Flag Register Bank

This block keeps a vector of interrupt flags for one peripheral and turns them into a single interrupt request line. Each hardware event input sets its own flag. Software uses a small register bus to read the flags, set them, clear them and enable them one bit at a time. The request output is the OR of every flag whose enable bit is set, and it comes from a register.

Software can also choose an atomic read-and-clear mode. With this mode on, a read of the clear register returns the flag vector. The same access then drops every flag that was set. This saves a separate write after the read, and no event that arrives in that cycle is lost.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset, the flag vector, the enable vector, `irq_o` and `rd_data_o` are all zero.
- R2: A high bit on `evt_i` sets the matching flag at that clock edge.
- R3: A write to address 1 (set register) ORs `wr_data_i` into the flags. A read of address 1 returns the flag vector.
- R4: A write to address 2 (clear register) clears each flag whose bit in `wr_data_i` is 1. Other flags keep their value.
- R5: Address 3 holds the enable vector and can be read and written. `irq_o` is the OR of flags ANDed with enables, taken from the state one cycle earlier. So it rises one cycle after a qualified flag becomes set.
- R6: When `rc_mode_i` is 1, a read of address 2 returns the current flag vector and clears every flag that was set.
- R7: When `rc_mode_i` is 0, a read of address 2 returns zero and leaves the flags unchanged.
- R8: If an event and a clear (written or by atomic read) hit the same flag in the same cycle, the flag ends up set.
- R9: Read data appears on `rd_data_o` at the clock edge that samples `rd_en_i`. Address 0 returns the flag vector. Unmapped addresses (4 to 7) return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register word address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | NUM_FLAGS | Write data / bit mask |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | NUM_FLAGS | Registered read data |
| evt_i | input | NUM_FLAGS | Hardware event pulses, one per flag |
| rc_mode_i | input | 1 | Enables atomic read-and-clear on the clear register |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Two functions can land on the same flag in the same cycle: the hardware event that sets it, and a software clear. The clear can come from a mask written to the clear register or from an atomic read of that register. The bench first sets a flag, then pulses its event input on the same edge as a clear write. A second case pulses a different event on the same edge as an atomic read. In both cases the flag vector is then read back through the bus, and the scoreboard expects the event bits to stay set. In the atomic case it also expects the returned data to show the flags as they stood before the clear.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_FLAG = 3'd0,
    REG_SET  = 3'd1,
    REG_CLR  = 3'd2,
    REG_EN   = 3'd3
  } reg_sel_e;
endpackage

// File: rtl/irqf_flag_reg.sv
module irqf_flag_reg #(
  parameter int NUM_FLAGS = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] evt_i,
  input  logic [NUM_FLAGS-1:0] set_mask_i,
  input  logic [NUM_FLAGS-1:0] clr_mask_i,
  output logic [NUM_FLAGS-1:0] flags_o
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic flag_q;
    logic flag_d;
    // set sources take priority over clear so no event is dropped
    always_comb begin
      flag_d = flag_q;
      if (clr_mask_i[i]) flag_d = 1'b0;
      if (set_mask_i[i] || evt_i[i]) flag_d = 1'b1;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= flag_d;
    end
    assign flags_o[i] = flag_q;
  end
endmodule

// File: rtl/irqf_reg_if.sv
module irqf_reg_if
  import irqf_pkg::*;
#(
  parameter int NUM_FLAGS = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  input  logic [NUM_FLAGS-1:0] wr_data_i,
  input  logic                 rd_en_i,
  input  logic                 rc_mode_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  output logic [NUM_FLAGS-1:0] set_mask_o,
  output logic [NUM_FLAGS-1:0] clr_mask_o,
  output logic [NUM_FLAGS-1:0] en_o,
  output logic [NUM_FLAGS-1:0] rd_data_o
);
  logic                 wr_set, wr_clr, wr_en_reg, rd_atomic;
  logic [NUM_FLAGS-1:0] en_q, rd_data_q, rd_mux;

  assign wr_set    = wr_en_i && (addr_i == REG_SET);
  assign wr_clr    = wr_en_i && (addr_i == REG_CLR);
  assign wr_en_reg = wr_en_i && (addr_i == REG_EN);
  assign rd_atomic = rd_en_i && rc_mode_i && (addr_i == REG_CLR);

  assign set_mask_o = wr_set ? wr_data_i : '0;
  // atomic read clears exactly the flags it returns
  assign clr_mask_o = (wr_clr ? wr_data_i : '0) | (rd_atomic ? flags_i : '0);

  always_comb begin
    unique case (addr_i)
      REG_FLAG, REG_SET: rd_mux = flags_i;
      REG_CLR:           rd_mux = rc_mode_i ? flags_i : '0;
      REG_EN:            rd_mux = en_q;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= '0;
      rd_data_q <= '0;
    end else begin
      if (wr_en_reg) en_q <= wr_data_i;
      if (rd_en_i)   rd_data_q <= rd_mux;
    end
  end

  assign en_o      = en_q;
  assign rd_data_o = rd_data_q;
endmodule

// File: rtl/irqf_irq_gen.sv
module irqf_irq_gen #(
  parameter int NUM_FLAGS = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic [NUM_FLAGS-1:0] en_i,
  output logic                 irq_o
);
  logic [NUM_FLAGS-1:0] qual;
  logic                 irq_q;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_qual
    assign qual[i] = flags_i[i] & en_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |qual;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irqf_pkg::*;
#(
  parameter int NUM_FLAGS = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  input  logic [NUM_FLAGS-1:0] wr_data_i,
  input  logic                 rd_en_i,
  output logic [NUM_FLAGS-1:0] rd_data_o,
  input  logic [NUM_FLAGS-1:0] evt_i,
  input  logic                 rc_mode_i,
  output logic                 irq_o
);
  logic [NUM_FLAGS-1:0] flags_q, en_q, set_mask, clr_mask;

  irqf_reg_if #(.NUM_FLAGS(NUM_FLAGS)) u_reg_if (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_en_i    (rd_en_i),
    .rc_mode_i  (rc_mode_i),
    .flags_i    (flags_q),
    .set_mask_o (set_mask),
    .clr_mask_o (clr_mask),
    .en_o       (en_q),
    .rd_data_o  (rd_data_o)
  );

  irqf_flag_reg #(.NUM_FLAGS(NUM_FLAGS)) u_flag_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_i),
    .set_mask_i (set_mask),
    .clr_mask_i (clr_mask),
    .flags_o    (flags_q)
  );

  irqf_irq_gen #(.NUM_FLAGS(NUM_FLAGS)) u_irq_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flags_i (flags_q),
    .en_i    (en_q),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/irqf_chk.sv
module irqf_chk
  import irqf_pkg::*;
#(
  parameter int NUM_FLAGS = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 wr_en_i,
  input logic [NUM_FLAGS-1:0] wr_data_i,
  input logic                 rd_en_i,
  input logic [NUM_FLAGS-1:0] evt_i,
  input logic                 rc_mode_i,
  input logic                 irq_o,
  input logic [NUM_FLAGS-1:0] flags,
  input logic [NUM_FLAGS-1:0] en
);
  // R2
  evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((flags & $past(evt_i)) == $past(evt_i)));

  // R4
  clr_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == REG_CLR) |=> ((flags & $past(wr_data_i) & ~$past(evt_i)) == '0));

  // R5
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flags & en)) |=> irq_o);

  // R5
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(flags & en)) |=> !irq_o);

  // R6
  rc_read_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rc_mode_i && addr_i == REG_CLR && !wr_en_i && evt_i == '0) |=> (flags == '0));

  // R7
  plain_read_no_effect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rc_mode_i && addr_i == REG_CLR && !wr_en_i && evt_i == '0) |=> $stable(flags));
endmodule

bind irq_flag_bank irqf_chk #(.NUM_FLAGS(NUM_FLAGS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_en_i   (rd_en_i),
  .evt_i     (evt_i),
  .rc_mode_i (rc_mode_i),
  .irq_o     (irq_o),
  .flags     (flags_q),
  .en        (en_q)
);

// File: tb/irq_flag_bank_tb.sv
module irq_flag_bank_tb;
  localparam int N = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   addr_i = '0;
  logic         wr_en_i = 1'b0;
  logic [N-1:0] wr_data_i = '0;
  logic         rd_en_i = 1'b0;
  logic [N-1:0] rd_data_o;
  logic [N-1:0] evt_i = '0;
  logic         rc_mode_i = 1'b0;
  logic         irq_o;

  int errors = 0;
  int checks = 0;
  logic [N-1:0] exp_q[$];
  string        tag_q[$];
  logic         mon_due = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_flag_bank #(.NUM_FLAGS(N)) u_dut (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wr_data_i, .rd_en_i,
    .rd_data_o, .evt_i, .rc_mode_i, .irq_o
  );

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: read data is due on the negedge after the sampling edge
  always @(posedge clk_i) mon_due <= rd_en_i;
  always @(negedge clk_i) begin
    if (mon_due) begin
      if (exp_q.size() == 0) check("scoreboard underflow", '1, '0);
      else check(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bus_write(logic [2:0] a, logic [N-1:0] d, logic [N-1:0] ev = '0);
    @(negedge clk_i);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1; evt_i = ev;
    @(negedge clk_i);
    wr_en_i = 1'b0; evt_i = '0;
  endtask

  task automatic bus_read(logic [2:0] a, logic [N-1:0] exp, string tag, logic [N-1:0] ev = '0);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1; evt_i = ev;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk_i);
    rd_en_i = 1'b0; evt_i = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    idle(2);
    // R1 reset state
    check("R1 irq", {{(N-1){1'b0}}, irq_o}, '0);
    check("R1 rd_data", rd_data_o, '0);
    rst_ni = 1'b1;
    bus_read(3'd0, '0, "R1 flags");
    bus_read(3'd3, '0, "R1 enable");

    // R2 event sets flag
    @(negedge clk_i); evt_i = 16'h0008;
    @(negedge clk_i); evt_i = '0;
    bus_read(3'd0, 16'h0008, "R2 event flag");
    check("R5 irq masked", {{(N-1){1'b0}}, irq_o}, '0);

    // R5 enable and irq latency
    bus_write(3'd3, 16'h0008);
    check("R5 irq one cycle late", {{(N-1){1'b0}}, irq_o}, '0);
    idle(1);
    check("R5 irq high", {{(N-1){1'b0}}, irq_o}, 1);
    bus_read(3'd3, 16'h0008, "R5 enable readback");

    // R3 set register
    bus_write(3'd1, 16'h00F0);
    bus_read(3'd1, 16'h00F8, "R3 set readback");

    // R4 clear register
    bus_write(3'd2, 16'h0018);
    bus_read(3'd0, 16'h00E0, "R4 clear mask");
    check("R5 irq low", {{(N-1){1'b0}}, irq_o}, '0);

    // R7 plain read of clear register
    rc_mode_i = 1'b0;
    bus_read(3'd2, '0, "R7 read returns zero");
    bus_read(3'd0, 16'h00E0, "R7 flags kept");

    // R6 atomic read-and-clear
    rc_mode_i = 1'b1;
    bus_read(3'd2, 16'h00E0, "R6 atomic data");
    bus_read(3'd0, '0, "R6 flags cleared");

    // R8 event versus clear write in the same cycle
    bus_write(3'd1, 16'h0001);
    bus_write(3'd2, 16'h0001, 16'h0001);
    bus_read(3'd0, 16'h0001, "R8 event beats clear write");
    // R8 event versus atomic read in the same cycle
    bus_read(3'd2, 16'h0001, "R8 atomic data", 16'h0004);
    bus_read(3'd0, 16'h0004, "R8 event beats atomic clear");
    rc_mode_i = 1'b0;

    // R9 unmapped address and full pattern
    bus_read(3'd5, '0, "R9 unmapped");
    bus_write(3'd1, 16'hFFFF);
    bus_read(3'd0, 16'hFFFF, "R9 flag read all ones");
    bus_write(3'd3, 16'h8000);
    idle(1);
    check("R5 irq top bit", {{(N-1){1'b0}}, irq_o}, 1);
    bus_write(3'd2, 16'h8000);
    idle(1);
    check("R5 irq after top clear", {{(N-1){1'b0}}, irq_o}, '0);

    idle(2);
    if (exp_q.size() != 0) check("scoreboard drain", '1, '0);
    finish_run();
  end
endmodule